// File: doc/BRIEF.md
# Boolean Reachability Closure Engine

This block takes the adjacency matrix of a directed graph with `N` nodes and returns its reflexive transitive closure: bit (i,j) of the result is 1 when node j can be reached from node i along zero or more edges. A single-cycle start pulse captures the whole matrix from a parallel input. The diagonal is set to 1 as the matrix is loaded. The stored matrix is then squared once per clock cycle with a Boolean product, in which every result bit is the OR of N AND terms.

Each squaring doubles the longest path length the matrix accounts for (1, 2, 4, ...). The engine therefore stops after ceil(log2 N) squarings, when that length has reached at least N. A one-cycle done pulse marks completion, and the result stays on the parallel output until the next accepted start. Matrix bit (i,j) always sits at flat index i*N+j, with i the source node and j the destination node.

Top module: `reach_closure_engine`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted, `done` is 0 and the stored matrix on `reach_out` is all zeros after the next clock edge.
- R2: A `start` pulse sampled while the engine is idle loads `adj_in` with every diagonal bit (index i*N+i) forced to 1. For N > 1 this loaded matrix appears on `reach_out` after that edge.
- R3: Each later edge replaces the matrix M with the Boolean product P, where P[i][j] = OR over k of (M[i][k] AND M[k][j]). After t squarings, bit (i,j) is 1 exactly when a path of length 2^t or less leads from i to j.
- R4: `done` is high for exactly one cycle. It rises at the edge that completes squaring number ceil(log2 N), counting from the edge that accepted `start`.
- R5: When `done` is high, `reach_out` equals the reflexive transitive closure of the accepted adjacency matrix.
- R6: A `start` pulse that arrives while squarings are still pending is ignored: neither the result nor the timing of `done` changes.
- R7: After `done`, `reach_out` holds its value until the next accepted `start`.
- R8: With N = 1, `done` rises at the same edge that accepts `start`, and `reach_out` is 1 whatever `adj_in` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; accepted only while idle |
| adj_in | input | N*N | Adjacency matrix, bit i*N+j set for an edge from i to j |
| done | output | 1 | One-cycle pulse when the closure is ready |
| reach_out | output | N*N | Stored matrix; the closure once `done` has pulsed |

## Verification
The bench builds the engine twice. The first build uses N = 8, which needs three squarings. That is enough to see the loaded matrix, a partial power, the finished closure and a rejected start in the middle of a run, each in its own cycle. The second build uses N = 1, where no squarings are needed. It covers the degenerate timing, in which completion coincides with the accepting edge, and it covers the forced self-loop as the only result bit.

// File: rtl/closure_pkg.sv
package closure_pkg;

   // Number of squarings needed so that 2^count >= n.
   function automatic int square_count(input int n);
      int c;
      int p;
      c = 0;
      p = 1;
      while (p < n) begin
         p = p * 2;
         c = c + 1;
      end
      return c;
   endfunction

   // Flat index of matrix element (row, col) for an n x n matrix.
   function automatic int flat_idx(input int n, input int row, input int col);
      return row * n + col;
   endfunction

endpackage

// File: rtl/closure_diag_force.sv
module closure_diag_force #(
   parameter int N = 8
) (
   input  logic [N*N-1:0] m_in,
   output logic [N*N-1:0] m_out
);
   localparam int W = N * N;

   logic [W-1:0] diag_mask;

   for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar c = 0; c < N; c++) begin : g_col
         if (r == c) begin : g_on
            assign diag_mask[closure_pkg::flat_idx(N, r, c)] = 1'b1;
         end else begin : g_off
            assign diag_mask[closure_pkg::flat_idx(N, r, c)] = 1'b0;
         end
      end
   end

   assign m_out = m_in | diag_mask;
endmodule

// File: rtl/closure_bool_square.sv
module closure_bool_square #(
   parameter int N = 8
) (
   input  logic [N*N-1:0] m_in,
   output logic [N*N-1:0] m_sq
);
   for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar c = 0; c < N; c++) begin : g_col
         logic [N-1:0] terms;
         for (genvar k = 0; k < N; k++) begin : g_term
            assign terms[k] = m_in[closure_pkg::flat_idx(N, r, k)]
                            & m_in[closure_pkg::flat_idx(N, k, c)];
         end
         assign m_sq[closure_pkg::flat_idx(N, r, c)] = |terms;
      end
   end
endmodule

// File: rtl/closure_ctrl.sv
module closure_ctrl #(
   parameter int STEPS = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic load,
   output logic sq_en,
   output logic done
);
   logic busy_q;
   logic done_q;

   assign load  = start & ~busy_q;
   assign sq_en = busy_q;
   assign done  = done_q;

   if (STEPS == 0) begin : g_nostep
      assign busy_q = 1'b0;
      always_ff @(posedge clk) begin
         if (rst) done_q <= 1'b0;
         else     done_q <= load;
      end
   end else begin : g_count
      localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
      localparam logic [CW-1:0] LAST = CW'(STEPS - 1);
      logic [CW-1:0] cnt_q;
      logic          busy_r;

      assign busy_q = busy_r;

      always_ff @(posedge clk) begin
         if (rst) begin
            busy_r <= 1'b0;
            cnt_q  <= '0;
            done_q <= 1'b0;
         end else begin
            done_q <= 1'b0;
            if (load) begin
               busy_r <= 1'b1;
               cnt_q  <= '0;
            end else if (busy_r) begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST) begin
                  busy_r <= 1'b0;
                  done_q <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/reach_closure_engine.sv
module reach_closure_engine #(
   parameter int N = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic [N*N-1:0] adj_in,
   output logic           done,
   output logic [N*N-1:0] reach_out
);
   localparam int W     = N * N;
   localparam int STEPS = closure_pkg::square_count(N);

   if (N < 1) begin : g_bad_n
      $error("reach_closure_engine: N must be at least 1");
   end

   logic [W-1:0] mat_q;
   logic [W-1:0] loaded;
   logic [W-1:0] squared;
   logic         load;
   logic         sq_en;

   closure_diag_force #(.N(N)) diag_i (
      .m_in  (adj_in),
      .m_out (loaded)
   );

   closure_bool_square #(.N(N)) sq_i (
      .m_in (mat_q),
      .m_sq (squared)
   );

   closure_ctrl #(.STEPS(STEPS)) ctrl_i (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .load  (load),
      .sq_en (sq_en),
      .done  (done)
   );

   always_ff @(posedge clk) begin
      if (rst)        mat_q <= '0;
      else if (load)  mat_q <= loaded;
      else if (sq_en) mat_q <= squared;
   end

   assign reach_out = mat_q;
endmodule

// File: rtl/closure_chk.sv
module closure_chk #(
   parameter int N = 8
) (
   input logic           clk,
   input logic           rst,
   input logic           start,
   input logic [N*N-1:0] adj_in,
   input logic           done,
   input logic [N*N-1:0] reach_out
);
   localparam int W     = N * N;
   localparam int STEPS = closure_pkg::square_count(N);

   function automatic logic [W-1:0] diag_of();
      logic [W-1:0] m;
      m = '0;
      for (int i = 0; i < N; i++) m[i*N+i] = 1'b1;
      return m;
   endfunction

   localparam logic [W-1:0] DIAG = diag_of();

   // Independent timing model of an accepted run.
   logic run;
   int   run_cnt;
   logic exp_done;

   always_ff @(posedge clk) begin
      if (rst) begin
         run      <= 1'b0;
         run_cnt  <= 0;
         exp_done <= 1'b0;
      end else begin
         exp_done <= 1'b0;
         if (start && !run) begin
            if (STEPS == 0) begin
               exp_done <= 1'b1;
            end else begin
               run     <= 1'b1;
               run_cnt <= 0;
            end
         end else if (run) begin
            run_cnt <= run_cnt + 1;
            if (run_cnt == STEPS - 1) begin
               run      <= 1'b0;
               exp_done <= 1'b1;
            end
         end
      end
   end

   AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (rst) exp_done |-> done); // R4
   AST_DONE_NOT_EARLY: assert property (@(posedge clk) disable iff (rst) done |-> exp_done); // R6
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> !done); // R4
   AST_RESULT_REFLEXIVE: assert property (@(posedge clk) disable iff (rst) done |-> ((reach_out & DIAG) == DIAG)); // R5
   AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> $stable(reach_out)); // R7
   AST_LOAD_FORCED: assert property (@(posedge clk) disable iff (rst) (start && !run && STEPS > 0) |=> (reach_out == ($past(adj_in) | DIAG))); // R2
endmodule

bind reach_closure_engine closure_chk #(.N(N)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .start     (start),
   .adj_in    (adj_in),
   .done      (done),
   .reach_out (reach_out)
);

// File: tb/reach_closure_engine_tb_top.sv
module reach_closure_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NB    = 8;
   localparam int WB    = NB * NB;
   localparam int STEPS = 3;
   localparam int NVEC  = 6;

   localparam logic [WB-1:0] VEC [NVEC] = '{
      64'h0000_0000_0000_0000,
      64'hFFFF_FFFF_FFFF_FFFF,
      64'h0080_4020_1008_0402,
      64'h0180_4020_1008_0402,
      64'h0000_0000_0000_0402,
      64'h8040_2010_0804_0201
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [WB-1:0] adj_in = '0;
   logic          done;
   logic [WB-1:0] reach_out;

   logic          start1 = 1'b0;
   logic [0:0]    adj1 = 1'b0;
   logic          done1;
   logic [0:0]    reach1;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   reach_closure_engine #(.N(NB)) dut_i (
      .clk(clk), .rst(rst), .start(start), .adj_in(adj_in),
      .done(done), .reach_out(reach_out)
   );

   reach_closure_engine #(.N(1)) dut1_i (
      .clk(clk), .rst(rst), .start(start1), .adj_in(adj1),
      .done(done1), .reach_out(reach1)
   );

   function automatic logic [WB-1:0] with_diag(input logic [WB-1:0] a);
      logic [WB-1:0] r;
      r = a;
      for (int i = 0; i < NB; i++) r[i*NB+i] = 1'b1;
      return r;
   endfunction

   function automatic logic [WB-1:0] ref_closure(input logic [WB-1:0] a);
      logic [WB-1:0] r;
      r = with_diag(a);
      for (int k = 0; k < NB; k++)
         for (int i = 0; i < NB; i++)
            for (int j = 0; j < NB; j++)
               if (r[i*NB+k] && r[k*NB+j]) r[i*NB+j] = 1'b1;
      return r;
   endfunction

   // Paths of length 2 or less, by explicit enumeration of middle nodes.
   function automatic logic [WB-1:0] ref_two_hop(input logic [WB-1:0] a);
      logic [WB-1:0] m;
      logic [WB-1:0] r;
      m = with_diag(a);
      r = '0;
      for (int i = 0; i < NB; i++)
         for (int j = 0; j < NB; j++)
            for (int k = 0; k < NB; k++)
               if (m[i*NB+k] && m[k*NB+j]) r[i*NB+j] = 1'b1;
      return r;
   endfunction

   task automatic chk(input string req, input logic [WB-1:0] act, input logic [WB-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Full run: accepted start, loaded matrix, first power, completion, hold.
   task automatic run_case(input logic [WB-1:0] a);
      logic [WB-1:0] cl;
      cl = ref_closure(a);
      @(negedge clk);
      start  = 1'b1;
      adj_in = a;
      @(negedge clk);
      start  = 1'b0;
      adj_in = ~a;
      chk("R2 loaded matrix", reach_out, with_diag(a));
      @(negedge clk);
      chk("R3 two-hop power", reach_out, ref_two_hop(a));
      chk("R4 done low mid-run", {63'd0, done}, 64'd0);
      @(negedge clk);
      chk("R4 done low before last", {63'd0, done}, 64'd0);
      @(negedge clk);
      chk("R4 done at last squaring", {63'd0, done}, 64'd1);
      chk("R5 closure", reach_out, cl);
      @(negedge clk);
      chk("R4 done one cycle", {63'd0, done}, 64'd0);
      repeat (2) @(negedge clk);
      chk("R7 result held", reach_out, cl);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog R4: actual no completion expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [WB-1:0] a;
      logic [WB-1:0] b;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 reset done", {63'd0, done}, 64'd0);
      chk("R1 reset matrix", reach_out, 64'd0);
      rst = 1'b0;
      @(negedge clk);

      for (int v = 0; v < NVEC; v++) run_case(VEC[v]);
      for (int n = 0; n < 20; n++) begin
         a = {$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()};
         run_case(a);
      end

      // R6: start while busy is ignored
      a = VEC[2];
      b = 64'h0100_0000_0000_0000;
      @(negedge clk);
      start = 1'b1; adj_in = a;
      @(negedge clk);
      adj_in = b;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk("R6 no early done", {63'd0, done}, 64'd0);
      @(negedge clk);
      chk("R6 done timing kept", {63'd0, done}, 64'd1);
      chk("R6 result of first start", reach_out, ref_closure(a));
      @(negedge clk);

      // R7: hold across idle inputs changing
      adj_in = 64'h1234_5678_9ABC_DEF0;
      repeat (3) @(negedge clk);
      chk("R7 hold while idle", reach_out, ref_closure(a));

      // R1: reset in the middle of a run
      start = 1'b1; adj_in = VEC[1];
      @(negedge clk);
      start = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      chk("R1 mid-run reset matrix", reach_out, 64'd0);
      chk("R1 mid-run reset done", {63'd0, done}, 64'd0);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 no done after reset", {63'd0, done}, 64'd0);

      // R8: single node
      start1 = 1'b1; adj1 = 1'b0;
      @(negedge clk);
      start1 = 1'b0;
      chk("R8 n1 done", {63'd0, done1}, 64'd1);
      chk("R8 n1 result", {63'd0, reach1}, 64'd1);
      @(negedge clk);
      chk("R8 n1 done pulse", {63'd0, done1}, 64'd0);
      chk("R8 n1 held", {63'd0, reach1}, 64'd1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule